// File: doc/BRIEF.md
# Time-Tag Record Writer

This block turns timing events into 32-bit records and stores them in a memory it treats as one circular FIFO. An internal timer measures the cycles since the last accepted start, and a macro counter runs freely from reset. When a stop event arrives, the block forms a record and issues a write request. The address comes from an internal pointer that advances after every word and returns to zero after the last location. A running total of written words lets a reader work out how many entries are still unread.

Two record formats are available. In single-stop mode each event gives one word. Three fields are placed in that word by a programmable router: micro time, macro time and channel number. Each field has its own least significant bit position and width. In multi-stop mode each event gives a pair of words: the full 32-bit timer value, followed by a word that carries the channel number. Multi-stop runs either free-running, where one start begins the run, or resynchronised, where an internal periodic pulse replaces the start input.

Top module: `ttag_writer`

## Requirements
- R1: Each written word goes to the address after the previous word's address, modulo the memory depth `2**ADDR_W`.
- R2: While `run` is high, the word after address `2**ADDR_W-1` goes to address 0. While `run` is low, no new record begins.
- R3: A single-stop word is the OR of three placed fields. Micro time is the cycles since the last start (0 when start and stop share a cycle). Macro time is the clock cycles since reset was released. The third field is `stop_ch`, `CH_W` bits wide. Each field is masked to its configured width (32 or more means all bits) and shifted left to its configured LSB. Bits shifted above bit 31 are dropped.
- R4: In single-stop mode only the first stop after a start is recorded. A stop with no start since the last record is ignored.
- R5: A multi-stop event writes two words at adjacent addresses on consecutive cycles. The first word is the 32-bit cycle count since the start. The second word has bit 31 set and `stop_ch` in bits `CH_W-1:0`, with all other bits zero. A stop in the cycle the second word is issued is ignored.
- R6: In free-running multi-stop mode, the first start after `run` rises arms the timer. Later starts do not reset the timer until `run` falls.
- R7: In resync mode `start_i` is ignored. `sync_o` pulses for one cycle on the first cycle of `run` and then every `RESYNC_PERIOD` cycles. Each pulse restarts the timer.
- R8: A word pair never straddles the wrap. If a pair would begin at the last address, that address is skipped and the pair begins at address 0.
- R9: `wr_count` increases by one for each word written, and wraps at 2**32.
- R10: During reset and until the first event, `wr_en` is low and `wr_count` is 0. The first word goes to address 0.
- R11: When `run` falls after the first word of a pair, the second word is still written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Recording enable; low acts as the stop command |
| multi_stop | input | 1 | 1 = two-word multi-stop records, 0 = single-stop words |
| resync | input | 1 | In multi-stop mode, 1 = internal periodic start |
| start_i | input | 1 | Start pulse |
| stop_i | input | 1 | Stop event |
| stop_ch | input | CH_W | Channel number of the stop event |
| cfg_micro_lsb | input | 5 | LSB position of the micro-time field |
| cfg_micro_len | input | 6 | Width of the micro-time field |
| cfg_macro_lsb | input | 5 | LSB position of the macro-time field |
| cfg_macro_len | input | 6 | Width of the macro-time field |
| cfg_ch_lsb | input | 5 | LSB position of the channel field |
| sync_o | output | 1 | Internal periodic start pulse |
| wr_en | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 32 | Write data |
| wr_count | output | 32 | Total words written |

## Verification
A behavioural model in the bench predicts every output on every cycle. The bench first tries single-stop records with two router layouts. One layout is disjoint. The other overlaps and pushes bits off the top of the word, which separates masking errors from shifting errors. Stops without a start, and start and stop in the same cycle, separate the arming rules. In free-running mode, repeated starts and back-to-back stops show whether starts are really ignored and whether the second-word cycle drops events. In resync mode, start pulses and stops land at several phases of the internal period. Long runs of one-cycle records drive the pointer around the ring, and one pair is aimed at the last address, which exposes a split pair. Run is dropped right after a first word, and a random phase mixes all modes.

// File: rtl/ttag_writer.sv
module ttag_writer #(
  parameter int ADDR_W        = 8,
  parameter int CH_W          = 2,
  parameter int RESYNC_PERIOD = 20,
  localparam int RS_W         = $clog2(RESYNC_PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              multi_stop,
  input  logic              resync,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CH_W-1:0]   stop_ch,
  input  logic [4:0]        cfg_micro_lsb,
  input  logic [5:0]        cfg_micro_len,
  input  logic [4:0]        cfg_macro_lsb,
  input  logic [5:0]        cfg_macro_len,
  input  logic [4:0]        cfg_ch_lsb,
  output logic              sync_o,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [31:0]       wr_count
);

  logic [RS_W-1:0]   rs_cnt;
  logic [31:0]       timer, macro_cnt, t_now;
  logic [ADDR_W-1:0] nxt_addr, pair_addr;
  logic [CH_W-1:0]   pend_ch;
  logic              armed, pend, start_eff, armed_eff, hit;

  function automatic logic [31:0] place(input logic [31:0] v, input logic [5:0] len,
                                        input logic [4:0] lsb);
    logic [31:0] m;
    m = (len >= 6'd32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    return (v & m) << lsb;
  endfunction

  assign sync_o    = run & multi_stop & resync & (rs_cnt == '0);
  assign start_eff = run & (multi_stop ? (resync ? sync_o : (start_i & ~armed)) : start_i);
  assign armed_eff = armed | start_eff;
  assign t_now     = start_eff ? 32'd0 : timer;
  assign hit       = run & stop_i & armed_eff & ~pend;
  assign pair_addr = (&nxt_addr) ? '0 : nxt_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_cnt    <= '0;
      timer     <= '0;
      macro_cnt <= '0;
      armed     <= 1'b0;
    end else begin
      if (!run)                                     rs_cnt <= '0;
      else if (rs_cnt == RS_W'(RESYNC_PERIOD - 1))  rs_cnt <= '0;
      else                                          rs_cnt <= rs_cnt + 1'b1;
      timer     <= start_eff ? 32'd1 : timer + 32'd1;
      macro_cnt <= macro_cnt + 32'd1;
      armed     <= run & ~(hit & ~multi_stop) & armed_eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_ch  <= '0;
      nxt_addr <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_count <= '0;
    end else begin
      pend    <= hit & multi_stop;
      pend_ch <= stop_ch;
      wr_en   <= pend | hit;
      if (pend) begin
        wr_addr  <= nxt_addr;
        wr_data  <= {1'b1, 31'(pend_ch)};
        nxt_addr <= nxt_addr + 1'b1;
        wr_count <= wr_count + 32'd1;
      end else if (hit && multi_stop) begin
        wr_addr  <= pair_addr;
        wr_data  <= t_now;
        nxt_addr <= pair_addr + 1'b1;
        wr_count <= wr_count + 32'd1;
      end else if (hit) begin
        wr_addr  <= nxt_addr;
        wr_data  <= place(t_now, cfg_micro_len, cfg_micro_lsb)
                  | place(macro_cnt, cfg_macro_len, cfg_macro_lsb)
                  | place(32'(stop_ch), 6'(CH_W), cfg_ch_lsb);
        nxt_addr <= nxt_addr + 1'b1;
        wr_count <= wr_count + 32'd1;
      end
    end
  end

  // R5 and R8: the second word follows at once at the next address
  a_r8_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> wr_en && !wr_data[31] ##1 wr_en && wr_data[31] && wr_addr == $past(wr_addr) + 1'b1);

  // R1: consecutive writes go to consecutive addresses, except at the wrap
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1 || wr_addr == '0);

  // R9: the count follows the writes
  a_r9_count_inc: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_count == $past(wr_count) + 32'd1);
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> $stable(wr_count));

  // R2: with run low, only the second word of a pair already begun may follow
  a_r2_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !pend |=> !wr_en);

  // R7: the sync pulse lasts one cycle
  a_r7_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sync_o && run |=> !sync_o);

endmodule

// File: tb/ttag_writer_tb.sv
module ttag_writer_tb;
  localparam int ADDR_W = 8;
  localparam int CH_W   = 2;
  localparam int PER    = 20;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0, rst_n = 0;
  logic run = 0, multi_stop = 0, resync = 0, start_i = 0, stop_i = 0;
  logic [CH_W-1:0] stop_ch = 0;
  logic [4:0] cfg_micro_lsb = 0, cfg_macro_lsb = 12, cfg_ch_lsb = 30;
  logic [5:0] cfg_micro_len = 12, cfg_macro_len = 18;
  logic sync_o, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data, wr_count;

  always #4 clk = ~clk;

  ttag_writer #(.ADDR_W(ADDR_W), .CH_W(CH_W), .RESYNC_PERIOD(PER)) u_dut (.*);

  int checks = 0, fails = 0;
  string cur_req = "R10";
  bit done = 0;

  // reference model state
  int unsigned m_tm, m_mac, m_addr, m_cnt, m_rs, m_pch;
  bit m_armed, m_pend, e_en;
  int unsigned e_addr, e_data;

  function automatic int unsigned route(int unsigned mic, int unsigned mac, int unsigned ch);
    int unsigned r = 0;
    for (int i = 0; i < 32; i++) begin
      if (i >= cfg_micro_lsb && (i - cfg_micro_lsb) < cfg_micro_len) r[i] = mic[i - cfg_micro_lsb];
      if (i >= cfg_macro_lsb && (i - cfg_macro_lsb) < cfg_macro_len) r[i] = r[i] | mac[i - cfg_macro_lsb];
      if (i >= cfg_ch_lsb && (i - cfg_ch_lsb) < CH_W) r[i] = r[i] | ch[i - cfg_ch_lsb];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tm = 0; m_mac = 0; m_addr = 0; m_cnt = 0; m_rs = 0; m_pch = 0;
      m_armed = 0; m_pend = 0; e_en = 0; e_addr = 0; e_data = 0;
    end else begin
      bit sy, st, hit, ae;
      int unsigned t;
      sy = run && multi_stop && resync && m_rs == 0;
      st = run && (multi_stop ? (resync ? sy : (start_i && !m_armed)) : start_i);
      t  = st ? 0 : m_tm;
      ae = m_armed || st;
      hit = run && stop_i && ae && !m_pend;
      e_en = 0;
      if (m_pend) begin
        e_en = 1; e_addr = m_addr; e_data = 32'h8000_0000 | m_pch;
      end else if (hit) begin
        e_en = 1;
        if (multi_stop) begin
          if (m_addr == DEPTH - 1) m_addr = 0;
          e_data = t;
        end else e_data = route(t, m_mac, stop_ch);
        e_addr = m_addr;
      end
      if (e_en) begin m_addr = (m_addr + 1) % DEPTH; m_cnt++; end
      m_pend  = hit && multi_stop;
      m_pch   = stop_ch;
      m_armed = run && !(hit && !multi_stop) && ae;
      m_tm    = st ? 1 : m_tm + 1;
      m_mac++;
      m_rs    = run ? ((m_rs == PER - 1) ? 0 : m_rs + 1) : 0;
    end
  end

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(cur_req, "wr_en", wr_en, e_en);
    chk("R9", "wr_count", wr_count, m_cnt);
    chk("R7", "sync_o", sync_o, rst_n && run && multi_stop && resync && m_rs == 0);
    if (e_en && wr_en) begin
      chk("R1", "wr_addr", wr_addr, e_addr);
      chk(cur_req, "wr_data", wr_data, e_data);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic ev(bit s, bit p, int ch);
    start_i = s; stop_i = p; stop_ch = CH_W'(ch); cyc(); start_i = 0; stop_i = 0;
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    // R10: nothing written before any event
    cur_req = "R10"; run = 1; cyc(3);
    // R3: single-stop word with disjoint fields
    cur_req = "R3";
    ev(1, 0, 0); cyc(4); ev(0, 1, 1);
    ev(1, 1, 2); cyc(2);
    // R4: extra stops after the first and stops without a start are dropped
    cur_req = "R4";
    ev(1, 0, 0); cyc(2); ev(0, 1, 3); ev(0, 1, 2); cyc(1); ev(0, 1, 1); ev(0, 1, 0);
    // R3: overlapping and truncated layout
    cur_req = "R3";
    cfg_micro_lsb = 28; cfg_micro_len = 8; cfg_macro_lsb = 4; cfg_macro_len = 40; cfg_ch_lsb = 31;
    ev(1, 0, 0); cyc(9); ev(0, 1, 3); ev(1, 1, 1); cyc(2);
    // R5 and R6: free-running multi-stop
    run = 0; cyc(2); multi_stop = 1; run = 1;
    cur_req = "R5";
    ev(0, 1, 1); cyc(2);
    ev(1, 0, 0); cyc(5); ev(0, 1, 2); ev(0, 1, 3); cyc(2);
    cur_req = "R6";
    ev(1, 0, 0); cyc(7); ev(0, 1, 1); cyc(3); ev(1, 1, 2); cyc(4);
    // R11: run drops right after the first word
    cur_req = "R11";
    ev(0, 1, 3); run = 0; cyc(4);
    // R7: resync mode
    cur_req = "R7"; resync = 1; run = 1;
    for (int k = 0; k < 60; k++) begin
      start_i = (k % 7 == 0); stop_i = (k % 5 == 1); stop_ch = CH_W'(k); cyc();
    end
    start_i = 0; stop_i = 0; run = 0; resync = 0; multi_stop = 0; cyc(2);
    // R2: one-cycle single records around the ring
    cur_req = "R2"; run = 1;
    cfg_micro_lsb = 0; cfg_micro_len = 12; cfg_macro_lsb = 12; cfg_macro_len = 18; cfg_ch_lsb = 30;
    start_i = 1; stop_i = 1;
    for (int k = 0; k < DEPTH + 20; k++) begin stop_ch = CH_W'(k); cyc(); end
    // R8: a pair aimed at the last address
    cur_req = "R8";
    while (m_addr != DEPTH - 1) cyc();
    multi_stop = 1; stop_ch = 2; cyc(); start_i = 0; stop_i = 0; cyc(4);
    run = 0; cyc(2); start_i = 1; stop_i = 1; multi_stop = 0; run = 1;
    while (m_addr != DEPTH - 2) cyc();
    multi_stop = 1; stop_ch = 1; cyc(); start_i = 0; stop_i = 0; cyc(4);
    // R2: run low blocks new records
    cur_req = "R2"; run = 0; multi_stop = 0;
    for (int k = 0; k < 10; k++) ev(1, 1, k);
    // mixed random traffic
    cur_req = "R3";
    for (int k = 0; k < 3000; k++) begin
      if (k % 200 == 0) begin
        run = 0; cyc(); multi_stop = $urandom_range(0, 1); resync = $urandom_range(0, 1);
        cur_req = multi_stop ? (resync ? "R7" : "R6") : "R4";
      end
      run = ($urandom_range(0, 19) != 0);
      start_i = ($urandom_range(0, 5) == 0);
      stop_i = ($urandom_range(0, 2) == 0);
      stop_ch = CH_W'($urandom);
      cyc();
    end
    run = 0; start_i = 0; stop_i = 0; cyc(3);
    finish_run();
  end
endmodule